// File: doc/BRIEF.md
# Long-Frame SPI Receive Master

This block is an SPI master that clocks one chip-select frame whose length is set in bits. The frame may be much longer than the 32-bit data word. It is meant for reading chains of converters wired in series. In such a chain the data of every device in the chain must come out in one unbroken frame, because each new chip-select assertion restarts the chain at its first bit.

The host pushes 32-bit words into a transmit FIFO and pops 32-bit words from a receive FIFO. The engine splits the frame into as many words as it needs. Every word carries 32 bits except possibly the final one, which carries whatever bits are left. Chip select stays low from the first bit of the frame to the last, across all word boundaries. If the transmit FIFO runs dry partway through a frame, the clock stops with chip select still asserted. The frame resumes when the host supplies the next word.

The block uses one fixed SPI mode. The clock idles low, the master launches MOSI on falling edges, and both sides sample on rising edges. The SCLK half period is a parameter counted in system clocks.

Top module: `lfspi_master`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0, both FIFOs are empty, neither FIFO is full, and rx_overrun is 0.
- R2: A frame produces exactly cfg_len_m1+1 rising SCLK edges. The length is captured when the frame starts.
- R3: Chip select falls once per frame and stays low across every word of the frame. Chip select changes only while SCLK is low.
- R4: A frame of L bits consumes ceil(L/32) transmit words and produces the same number of receive words. Each word carries 32 bits except the last, which carries L mod 32 bits when that value is nonzero.
- R5: For each transmit word carrying n bits, only bits n-1 down to 0 are sent, most significant first. Higher bits of that word are ignored. MOSI changes only while SCLK is low.
- R6: Each receive word holds its n received bits right-aligned, with the first received bit in bit n-1 and zeros above. MISO is sampled on the rising SCLK edge.
- R7: If the transmit FIFO is empty at a word boundary inside a frame, SCLK stays low and chip select stays low until a word is pushed. The frame then continues without a new chip-select assertion.
- R8: A transmit word pushed beyond what the current frame needs starts a new frame. Chip select goes high between the two frames.
- R9: A receive word that completes while the receive FIFO is full is dropped, and the words already stored are kept. This event sets rx_overrun, which then stays 1 until reset.
- R10: Each FIFO holds 16 words. tx_full is 1 at 16 stored words, and a push while the FIFO is full is ignored.
- R11: SCLK is low whenever chip select is deasserted. Each SCLK half period lasts SCLK_HALF_DIV system clocks.
- R12: A pop from an empty receive FIFO has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len_m1 | input | 12 | Frame length in bits minus one |
| tx_push | input | 1 | Write tx_word into the transmit FIFO |
| tx_word | input | 32 | Transmit word; the low bits are used for a partial word |
| tx_full | output | 1 | Transmit FIFO holds 16 words |
| tx_empty | output | 1 | Transmit FIFO holds no word |
| rx_pop | input | 1 | Remove the head word of the receive FIFO |
| rx_word | output | 32 | Head word of the receive FIFO |
| rx_full | output | 1 | Receive FIFO holds 16 words |
| rx_empty | output | 1 | Receive FIFO holds no word |
| rx_overrun | output | 1 | Sticky flag: a received word was dropped |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
The hardest state to reach from the ports is a frame that is still open at a word boundary with no transmit word waiting. The engine pops the first word as soon as it is written, so the stall only appears when the bench deliberately starves a 40-bit frame. The bench pushes only the first word, waits until 32 rising edges have been counted, and observes the idle clock with chip select low. It then supplies the tail word.

Overrun is also awkward to reach. It needs a single 544-bit frame that outruns a 16-deep receive FIFO that is never drained. That frame is fed while the transmit FIFO sits full, so the same run also exercises a push into a full FIFO. A behavioural slave shift register drives MISO and records MOSI, so every bit position of each word is compared against values computed from the vector table.

// File: rtl/lfspi_pkg.sv
package lfspi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOW   = 3'd1,
    ST_HIGH  = 3'd2,
    ST_STALL = 3'd3,
    ST_TAIL  = 3'd4
  } eng_state_t;

endpackage

// File: rtl/lfspi_fifo.sv
module lfspi_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          wr_en, rd_en;

  assign wr_en = push && !full;
  assign rd_en = pop && !empty;
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign rdata = mem[rd_ptr];

  // Storage array without reset so it can map to RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/lfspi_tick.sv
module lfspi_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/lfspi_engine.sv
module lfspi_engine
  import lfspi_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int SIZE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SIZE_W-1:0] len_m1,
  input  logic              tx_empty,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              rx_full,
  input  logic              spi_miso,
  input  logic              tick,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [WORD_W-1:0] rx_data,
  output logic              overrun,
  output logic              tick_run,
  output eng_state_t        state,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n
);
  localparam int REM_W = SIZE_W + 1;
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [REM_W-1:0]  frame_rem, rem_sel;
  logic [CNT_W-1:0]  word_left, ld_n;
  logic [WORD_W-1:0] tx_sr, rx_sr, ld_word, rx_next;
  logic              word_end, do_load;

  always_comb begin
    rem_sel  = (state == ST_IDLE) ? (REM_W'(len_m1) + REM_W'(1)) : frame_rem;
    ld_n     = (rem_sel > REM_W'(WORD_W)) ? CNT_W'(WORD_W) : rem_sel[CNT_W-1:0];
    // Left-justify the valid low bits so the shifter always sends bit WORD_W-1.
    ld_word  = tx_data << (CNT_W'(WORD_W) - ld_n);
    rx_next  = {rx_sr[WORD_W-2:0], spi_miso};
    word_end = (state == ST_HIGH) && tick && (word_left == '0);
    do_load  = !tx_empty &&
               ((state == ST_IDLE) || (state == ST_STALL) ||
                (word_end && (frame_rem != '0)));
    tx_pop   = do_load;
    tick_run = (state == ST_LOW) || (state == ST_HIGH) || (state == ST_TAIL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      sclk      <= 1'b0;
      mosi      <= 1'b0;
      cs_n      <= 1'b1;
      frame_rem <= '0;
      word_left <= '0;
      tx_sr     <= '0;
      rx_sr     <= '0;
      rx_push   <= 1'b0;
      rx_data   <= '0;
      overrun   <= 1'b0;
    end else begin
      rx_push <= 1'b0;
      if (rx_push && rx_full) overrun <= 1'b1;

      if (do_load) begin
        tx_sr     <= ld_word;
        mosi      <= ld_word[WORD_W-1];
        word_left <= ld_n;
        frame_rem <= rem_sel - REM_W'(ld_n);
        rx_sr     <= '0;
        sclk      <= 1'b0;
        cs_n      <= 1'b0;
        state     <= ST_LOW;
      end else begin
        case (state)
          ST_LOW: if (tick) begin
            sclk      <= 1'b1;
            rx_sr     <= rx_next;
            word_left <= word_left - 1'b1;
            if (word_left == CNT_W'(1)) begin
              rx_push <= 1'b1;
              rx_data <= rx_next;
            end
            state <= ST_HIGH;
          end
          ST_HIGH: if (tick) begin
            sclk <= 1'b0;
            if (word_left != '0) begin
              tx_sr <= tx_sr << 1;
              mosi  <= tx_sr[WORD_W-2];
              state <= ST_LOW;
            end else if (frame_rem == '0) begin
              state <= ST_TAIL;
            end else begin
              state <= ST_STALL;
            end
          end
          ST_TAIL: if (tick) begin
            cs_n  <= 1'b1;
            mosi  <= 1'b0;
            state <= ST_IDLE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lfspi_master.sv
module lfspi_master
  import lfspi_pkg::*;
#(
  parameter int WORD_W        = 32,
  parameter int SIZE_W        = 12,
  parameter int FIFO_DEPTH    = 16,
  parameter int SCLK_HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SIZE_W-1:0] cfg_len_m1,
  input  logic              tx_push,
  input  logic [WORD_W-1:0] tx_word,
  output logic              tx_full,
  output logic              tx_empty,
  input  logic              rx_pop,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_full,
  output logic              rx_empty,
  output logic              rx_overrun,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);
  logic [WORD_W-1:0] tx_head, rx_data;
  logic              tx_pop, rx_push, tick, tick_run;
  eng_state_t        eng_state;

  lfspi_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk(clk), .rst(rst), .push(tx_push), .wdata(tx_word), .pop(tx_pop),
    .rdata(tx_head), .full(tx_full), .empty(tx_empty)
  );

  lfspi_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk(clk), .rst(rst), .push(rx_push), .wdata(rx_data), .pop(rx_pop),
    .rdata(rx_word), .full(rx_full), .empty(rx_empty)
  );

  lfspi_tick #(.DIV(SCLK_HALF_DIV)) u_tick (
    .clk(clk), .rst(rst), .run(tick_run), .tick(tick)
  );

  lfspi_engine #(.WORD_W(WORD_W), .SIZE_W(SIZE_W)) u_eng (
    .clk(clk), .rst(rst), .len_m1(cfg_len_m1), .tx_empty(tx_empty),
    .tx_data(tx_head), .rx_full(rx_full), .spi_miso(spi_miso), .tick(tick),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data),
    .overrun(rx_overrun), .tick_run(tick_run), .state(eng_state),
    .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n)
  );
endmodule

// File: rtl/lfspi_checker.sv
module lfspi_checker
  import lfspi_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       spi_sclk,
  input logic       spi_mosi,
  input logic       spi_cs_n,
  input logic       tx_full,
  input logic       tx_empty,
  input logic       rx_full,
  input logic       rx_empty,
  input logic       rx_overrun,
  input eng_state_t eng_state
);
  assert_sclk_idle_R11: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk);

  assert_mosi_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  assert_cs_fall_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs_n) |-> !spi_sclk);

  assert_cs_rise_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_cs_n) |-> !spi_sclk);

  assert_stall_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (eng_state == ST_STALL) |-> (!spi_sclk && !spi_cs_n));

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    rx_overrun |=> rx_overrun);

  assert_tx_flags_R10: assert property (@(posedge clk) disable iff (rst)
    !(tx_full && tx_empty));

  assert_rx_flags_R10: assert property (@(posedge clk) disable iff (rst)
    !(rx_full && rx_empty));
endmodule

bind lfspi_master lfspi_checker u_lfspi_checker (
  .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
  .spi_cs_n(spi_cs_n), .tx_full(tx_full), .tx_empty(tx_empty),
  .rx_full(rx_full), .rx_empty(rx_empty), .rx_overrun(rx_overrun),
  .eng_state(eng_state)
);

// File: tb/lfspi_master_bench.sv
module lfspi_master_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] cfg_len_m1 = '0;
  logic        tx_push = 1'b0;
  logic [31:0] tx_word = '0;
  logic        rx_pop = 1'b0;
  logic        tx_full, tx_empty, rx_full, rx_empty, rx_overrun;
  logic [31:0] rx_word;
  logic        spi_sclk, spi_mosi, spi_miso, spi_cs_n;

  always #10 clk = ~clk;

  lfspi_master u_lfspi_master (
    .clk(clk), .rst(rst), .cfg_len_m1(cfg_len_m1), .tx_push(tx_push),
    .tx_word(tx_word), .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_pop(rx_pop), .rx_word(rx_word), .rx_full(rx_full),
    .rx_empty(rx_empty), .rx_overrun(rx_overrun), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  int checks = 0;
  int errors = 0;

  // Behavioural slave: a long shift register loaded at chip-select fall.
  logic [127:0] slave_pat = '0;
  logic [127:0] sl_sr = '0;
  logic [127:0] mosi_cap = '0;
  int rise_cnt = 0, cs_fall_cnt = 0, cs_rise_cnt = 0;

  assign spi_miso = sl_sr[127];
  always @(negedge spi_cs_n) begin sl_sr = slave_pat; cs_fall_cnt++; end
  always @(posedge spi_cs_n) cs_rise_cnt++;
  always @(posedge spi_sclk) begin mosi_cap = {mosi_cap[126:0], spi_mosi}; rise_cnt++; end
  always @(negedge spi_sclk) if (!spi_cs_n) sl_sr = sl_sr << 1;

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles, expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    while (tx_full) @(negedge clk);
    tx_word = w;
    tx_push = 1'b1;
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  logic [31:0] got [32];
  task automatic drain(output int n);
    n = 0;
    @(negedge clk);
    while (!rx_empty) begin
      if (n < 32) got[n] = rx_word;
      n++;
      rx_pop = 1'b1;
      @(negedge clk);
      rx_pop = 1'b0;
    end
  endtask

  task automatic clear_counts();
    rise_cnt = 0; cs_fall_cnt = 0; cs_rise_cnt = 0; mosi_cap = '0;
  endtask

  function automatic logic [127:0] make_pat(input logic [31:0] s);
    return {s, ~s, s ^ 32'h5A5A_A5A5, {s[15:0], s[31:16]}};
  endfunction

  function automatic logic [31:0] make_tx(input logic [31:0] s, input int k);
    return s ^ (32'h1357_9BDF * 32'(k + 1));
  endfunction

  // Vector table: {frame length minus one, seed}.
  localparam int NV = 8;
  localparam logic [43:0] VEC [NV] = '{
    {12'd0,  32'hC3A5_0F1E}, {12'd7,  32'h8001_7FFE}, {12'd30, 32'h1234_5678},
    {12'd31, 32'hDEAD_BEEF}, {12'd32, 32'hF0F0_0F0F}, {12'd35, 32'h9E37_79B9},
    {12'd63, 32'h0BAD_F00D}, {12'd71, 32'h7654_3210}
  };

  initial begin
    int n;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1", "cs_n/sclk in reset",
          {spi_cs_n, spi_sclk}, 2'b10);
    rst = 1'b0;
    @(negedge clk);
    check({tx_empty, rx_empty, tx_full, rx_full, rx_overrun} == 5'b11000, "R1",
          "flags after reset", {tx_empty, rx_empty, tx_full, rx_full, rx_overrun}, 5'b11000);

    // R12: pop on an empty receive FIFO is ignored
    rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0; @(negedge clk);
    check(rx_empty && !rx_full, "R12", "pop on empty", {rx_empty, rx_full}, 2'b10);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      logic [31:0]  seed;
      logic [127:0] exp_mosi;
      int           len, nw;
      seed = VEC[v][31:0];
      len  = int'(VEC[v][43:32]) + 1;
      nw   = (len + 31) / 32;
      clear_counts();
      slave_pat  = make_pat(seed);
      cfg_len_m1 = VEC[v][43:32];
      exp_mosi   = '0;
      for (int k = 0; k < nw; k++) begin
        int nb;
        logic [31:0] tw;
        nb = (len - 32 * k > 32) ? 32 : len - 32 * k;
        tw = make_tx(seed, k);
        for (int b = nb - 1; b >= 0; b--) exp_mosi = {exp_mosi[126:0], tw[b]};
        push(tw);
      end
      wait (cs_rise_cnt == 1);
      repeat (4) @(negedge clk);
      check(rise_cnt == len, "R2", "sclk rising edges", 128'(rise_cnt), 128'(len));
      check(cs_fall_cnt == 1, "R3", "cs assertions per frame", 128'(cs_fall_cnt), 128'd1);
      check(mosi_cap == exp_mosi, "R5", "mosi bit stream", mosi_cap, exp_mosi);
      check(spi_sclk == 1'b0 && spi_cs_n, "R11", "idle after frame", {spi_cs_n, spi_sclk}, 2'b10);
      drain(n);
      check(n == nw, "R4", "receive word count", 128'(n), 128'(nw));
      for (int k = 0; k < nw && k < n; k++) begin
        int nb;
        logic [31:0] ew;
        nb = (len - 32 * k > 32) ? 32 : len - 32 * k;
        ew = '0;
        for (int b = 0; b < nb; b++) ew = {ew[30:0], slave_pat[127 - (32 * k + b)]};
        check(got[k] == ew, "R6", "receive word", 128'(got[k]), 128'(ew));
      end
    end

    // R7: starve a 40-bit frame after its first word
    clear_counts();
    slave_pat  = make_pat(32'h3C3C_A0A0);
    cfg_len_m1 = 12'd39;
    push(32'hAAAA_5555);
    wait (rise_cnt == 32);
    repeat (20) @(negedge clk);
    check(!spi_cs_n && !spi_sclk && rise_cnt == 32, "R7", "stall holds cs low, sclk idle",
          {spi_cs_n, spi_sclk, 32'(rise_cnt)}, {2'b00, 32'd32});
    check(!rx_empty, "R7", "first word delivered during stall", 128'(rx_empty), 128'd0);
    push(32'h0000_00C3);
    wait (cs_rise_cnt == 1);
    repeat (4) @(negedge clk);
    check(rise_cnt == 40 && cs_fall_cnt == 1, "R7", "frame resumes without new cs",
          {32'(rise_cnt), 32'(cs_fall_cnt)}, {32'd40, 32'd1});
    check(mosi_cap[7:0] == 8'hC3, "R5", "tail word low bits", 128'(mosi_cap[7:0]), 128'hC3);
    drain(n);
    check(n == 2 && got[1] == {24'd0, slave_pat[95:88]}, "R6", "tail word right-aligned",
          128'(got[1]), {24'd0, slave_pat[95:88]});

    // R8: an extra word starts a second frame
    clear_counts();
    cfg_len_m1 = 12'd7;
    push(32'h0000_0081);
    push(32'h0000_0042);
    wait (cs_rise_cnt == 2);
    repeat (4) @(negedge clk);
    check(cs_fall_cnt == 2 && rise_cnt == 16, "R8", "two frames from two words",
          {32'(cs_fall_cnt), 32'(rise_cnt)}, {32'd2, 32'd16});
    drain(n);
    check(n == 2, "R8", "two receive words", 128'(n), 128'd2);

    // R9/R10: one 544-bit frame into an undrained receive FIFO
    clear_counts();
    slave_pat  = make_pat(32'h6B6B_1D1D);
    cfg_len_m1 = 12'd543;
    for (int k = 0; k < 17; k++) push(32'h100 + 32'(k));
    check(tx_full, "R10", "tx full at 16 words", 128'(tx_full), 128'd1);
    tx_word = 32'hFFFF_FFFF; tx_push = 1'b1; @(negedge clk); tx_push = 1'b0;
    wait (cs_rise_cnt == 1);
    repeat (40) @(negedge clk);
    check(rx_overrun && rx_full, "R9", "overrun flagged", {rx_overrun, rx_full}, 2'b11);
    check(tx_empty && cs_fall_cnt == 1 && rise_cnt == 544, "R10", "push while full ignored",
          {tx_empty, 32'(cs_fall_cnt), 32'(rise_cnt)}, {1'b1, 32'd1, 32'd544});
    drain(n);
    check(n == 16, "R10", "receive FIFO depth", 128'(n), 128'd16);
    check(got[0] == slave_pat[127:96], "R9", "stored words kept", 128'(got[0]), 128'(slave_pat[127:96]));
    check(rx_overrun, "R9", "overrun sticky after drain", 128'(rx_overrun), 128'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule